// File: doc/BRIEF.md
# Two-Phase State Timing Generator

This block creates the core's state timing references as single-cycle clock-enable pulses inside one fast clock domain. A select input picks the operating rate f: either the direct rate, or the rate after a fourfold multiplier. The multiplier itself is not modelled. It is represented by the fast clock and the select input. From f the block derives a state time of two clock periods t. The state time is divided into a first phase and a second phase. Each phase is announced by a one-cycle, active-high pulse, followed by idle cycles in which neither phase pulse is present.

Two groups of phase outputs leave the block: one for the processor and one for the peripherals. A low-power idle request silences only the processor group. A powerdown request silences both groups. A gating change takes effect only at the next state boundary, so a phase is never cut short. An internal clock-out level rises after each peripheral first-phase pulse and falls after each peripheral second-phase pulse. A free-running strobe marks the first cycle of every state so that state periods can be measured.

Top module: `state_phase_gen`

## Requirements
- R1: With `mult_sel` latched as 1, one t lasts SUB_CYC fast cycles. A state therefore spans 2*SUB_CYC cycles (4 with defaults). The second-phase pulse comes SUB_CYC cycles after the first-phase pulse.
- R2: With `mult_sel` latched as 0, one t lasts SUB_CYC*MULT fast cycles. A state spans 2*SUB_CYC*MULT cycles (16 with defaults). The second-phase pulse comes SUB_CYC*MULT cycles after the first-phase pulse.
- R3: Each phase output is high for exactly one cycle per state. The first phase comes before the second. The two are never high together, and every phase pulse is followed by a cycle with both low.
- R4: `state_stb` is high for one cycle at the first cycle of every state, whatever the idle and powerdown requests. A running peripheral first-phase pulse always coincides with it.
- R5: `clkout_int` goes high the cycle after a peripheral first-phase pulse and low the cycle after a peripheral second-phase pulse. Otherwise it holds.
- R6: While `idle_req` is sampled high (and `pdown_req` low), the processor phase outputs stay low. The peripheral phases continue, two pulses per state.
- R7: While `pdown_req` is sampled high, all four phase outputs stay low and `clkout_int` stays low. This holds regardless of `idle_req`.
- R8: `mult_sel`, `idle_req` and `pdown_req` are sampled only on the clock edge that starts a state. A change in the middle of a state leaves that state's length, its phase positions and its gating unchanged.
- R9: While `rst` is high, every output is low. On the first clock edge with `rst` low, a state begins: `state_stb` and the running first-phase outputs go high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, one cycle per SUB_CYC-th of t in multiplied mode |
| rst | input | 1 | Synchronous reset, active high |
| mult_sel | input | 1 | 1 selects the multiplied rate, 0 the direct rate |
| idle_req | input | 1 | Request to halt the processor phases |
| pdown_req | input | 1 | Request to halt all phases |
| cpu_ph1 | output | 1 | Processor first-phase enable pulse |
| cpu_ph2 | output | 1 | Processor second-phase enable pulse |
| per_ph1 | output | 1 | Peripheral first-phase enable pulse |
| per_ph2 | output | 1 | Peripheral second-phase enable pulse |
| clkout_int | output | 1 | Internal clock-out level, one period per state |
| state_stb | output | 1 | One-cycle marker of each state's first cycle |

## Verification
The bench builds the block with its defaults, SUB_CYC = 2 and MULT = 4. A state then takes 4 cycles in multiplied mode and 16 in direct mode, so every phase position in both modes is compared cycle by cycle. The bench sweeps all four combinations of the idle and powerdown requests under both rate selections. Each combination is held for differing lengths, so request and rate changes land at many positions inside a state. This exercises boundary-only sampling and the switch between state lengths. A reset taken during powerdown is also covered.

// File: rtl/stpg_pkg.sv
package stpg_pkg;

    // Position classes inside one state time
    typedef enum logic [1:0] {
        SLOT_PH1  = 2'd0,
        SLOT_GAP1 = 2'd1,
        SLOT_PH2  = 2'd2,
        SLOT_GAP2 = 2'd3
    } slot_e;

    // Domain indices for the gated phase groups
    localparam int unsigned DOM_CPU = 0;
    localparam int unsigned DOM_PER = 1;
    localparam int unsigned DOM_NUM = 2;

    // Fast cycles in one period t for the selected rate
    function automatic int unsigned half_cycles(input logic fast,
                                                input int unsigned sub_cyc,
                                                input int unsigned mult);
        return fast ? sub_cyc : sub_cyc * mult;
    endfunction

    // Map a position within the state to its slot
    function automatic slot_e classify(input int unsigned pos,
                                       input int unsigned half);
        slot_e s;
        if (pos == 0)         s = SLOT_PH1;
        else if (pos < half)  s = SLOT_GAP1;
        else if (pos == half) s = SLOT_PH2;
        else                  s = SLOT_GAP2;
        return s;
    endfunction

endpackage

// File: rtl/stpg_seq.sv
module stpg_seq
    import stpg_pkg::*;
#(
    parameter int unsigned SUB_CYC = 2,
    parameter int unsigned MULT    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic mult_sel,
    output logic bound_o,
    output logic ph1_o,
    output logic ph2_o,
    output logic stb_o
);

    localparam int unsigned T_SLOW    = SUB_CYC * MULT;
    localparam int unsigned STATE_MAX = 2 * T_SLOW;
    localparam int unsigned CW        = (STATE_MAX > 2) ? $clog2(STATE_MAX) : 1;

    typedef struct packed {
        logic [CW-1:0] pos;
        logic          fast;
        logic          start;
        logic          ph1;
        logic          ph2;
        logic          stb;
    } seq_t;

    seq_t        s_q, s_d;
    int unsigned cur_half;
    int unsigned nxt_half;
    slot_e       nxt_slot;
    logic        bound;

    always_comb begin
        s_d      = s_q;
        cur_half = half_cycles(s_q.fast, SUB_CYC, MULT);
        bound    = s_q.start || (32'(s_q.pos) == (2 * cur_half - 1));

        if (bound) begin
            s_d.pos  = '0;
            s_d.fast = mult_sel;
        end else begin
            s_d.pos  = s_q.pos + 1'b1;
        end
        s_d.start = 1'b0;

        nxt_half = half_cycles(s_d.fast, SUB_CYC, MULT);
        nxt_slot = classify(32'(s_d.pos), nxt_half);
        s_d.ph1  = (nxt_slot == SLOT_PH1);
        s_d.ph2  = (nxt_slot == SLOT_PH2);
        s_d.stb  = bound;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{pos: '0, fast: 1'b0, start: 1'b1, ph1: 1'b0, ph2: 1'b0, stb: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign bound_o = bound;
    assign ph1_o   = s_q.ph1;
    assign ph2_o   = s_q.ph2;
    assign stb_o   = s_q.stb;

    AST_STB_SPACING: assert property (@(posedge clk) disable iff (rst)
        stb_o |=> !stb_o); // R4

    AST_PH1_WITH_STB: assert property (@(posedge clk) disable iff (rst)
        ph1_o |-> stb_o); // R4

    AST_PH2_AFTER_PH1: assert property (@(posedge clk) disable iff (rst)
        ph2_o |-> !stb_o); // R3

endmodule

// File: rtl/stpg_gate.sv
module stpg_gate #(
    parameter bit HALT_ON_IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic bound_i,
    input  logic idle_req,
    input  logic pdown_req,
    input  logic raw_ph1,
    input  logic raw_ph2,
    input  logic stb_i,
    output logic ph1_o,
    output logic ph2_o
);

    typedef struct packed {
        logic run;
    } gate_t;

    gate_t g_q, g_d;
    logic  halt;

    generate
        if (HALT_ON_IDLE) begin : g_idle_stops
            assign halt = pdown_req | idle_req;
        end else begin : g_idle_passes
            assign halt = pdown_req;
        end
    endgenerate

    always_comb begin
        g_d = g_q;
        if (bound_i) begin
            g_d.run = ~halt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q <= '{run: 1'b1};
        end else begin
            g_q <= g_d;
        end
    end

    assign ph1_o = raw_ph1 & g_q.run;
    assign ph2_o = raw_ph2 & g_q.run;

    AST_GATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        !$stable(g_q.run) |-> stb_i); // R8

endmodule

// File: rtl/stpg_clkout.sv
module stpg_clkout (
    input  logic clk,
    input  logic rst,
    input  logic ph1_i,
    input  logic ph2_i,
    output logic lvl_o
);

    typedef struct packed {
        logic lvl;
    } ck_t;

    ck_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        if (ph1_i) begin
            c_d.lvl = 1'b1;
        end else if (ph2_i) begin
            c_d.lvl = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '{lvl: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign lvl_o = c_q.lvl;

endmodule

// File: rtl/state_phase_gen.sv
module state_phase_gen
    import stpg_pkg::*;
#(
    parameter int unsigned SUB_CYC = 2,
    parameter int unsigned MULT    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic mult_sel,
    input  logic idle_req,
    input  logic pdown_req,
    output logic cpu_ph1,
    output logic cpu_ph2,
    output logic per_ph1,
    output logic per_ph2,
    output logic clkout_int,
    output logic state_stb
);

    logic               bound;
    logic               raw_ph1;
    logic               raw_ph2;
    logic               stb;
    logic [DOM_NUM-1:0] dom_ph1;
    logic [DOM_NUM-1:0] dom_ph2;

    stpg_seq #(
        .SUB_CYC (SUB_CYC),
        .MULT    (MULT)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .mult_sel (mult_sel),
        .bound_o  (bound),
        .ph1_o    (raw_ph1),
        .ph2_o    (raw_ph2),
        .stb_o    (stb)
    );

    for (genvar d = 0; d < DOM_NUM; d++) begin : g_dom
        stpg_gate #(
            .HALT_ON_IDLE (d == DOM_CPU)
        ) u_gate (
            .clk       (clk),
            .rst       (rst),
            .bound_i   (bound),
            .idle_req  (idle_req),
            .pdown_req (pdown_req),
            .raw_ph1   (raw_ph1),
            .raw_ph2   (raw_ph2),
            .stb_i     (stb),
            .ph1_o     (dom_ph1[d]),
            .ph2_o     (dom_ph2[d])
        );
    end

    stpg_clkout u_clkout (
        .clk   (clk),
        .rst   (rst),
        .ph1_i (dom_ph1[DOM_PER]),
        .ph2_i (dom_ph2[DOM_PER]),
        .lvl_o (clkout_int)
    );

    assign cpu_ph1   = dom_ph1[DOM_CPU];
    assign cpu_ph2   = dom_ph2[DOM_CPU];
    assign per_ph1   = dom_ph1[DOM_PER];
    assign per_ph2   = dom_ph2[DOM_PER];
    assign state_stb = stb;

    AST_PH_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(per_ph1 && per_ph2)); // R3

    AST_PH1_GAP: assert property (@(posedge clk) disable iff (rst)
        per_ph1 |=> (!per_ph1 && !per_ph2)); // R3

    AST_PH2_GAP: assert property (@(posedge clk) disable iff (rst)
        per_ph2 |=> (!per_ph1 && !per_ph2)); // R3

    AST_CPU_PH1_IN_PER: assert property (@(posedge clk) disable iff (rst)
        cpu_ph1 |-> per_ph1); // R6

    AST_CPU_PH2_IN_PER: assert property (@(posedge clk) disable iff (rst)
        cpu_ph2 |-> per_ph2); // R7

    AST_PH1_ON_STB: assert property (@(posedge clk) disable iff (rst)
        per_ph1 |-> state_stb); // R4

    AST_CLK_RISE: assert property (@(posedge clk) disable iff (rst)
        per_ph1 |=> clkout_int); // R5

    AST_CLK_FALL: assert property (@(posedge clk) disable iff (rst)
        per_ph2 |=> !clkout_int); // R5

endmodule

// File: tb/state_phase_gen_bench.sv
module state_phase_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SUB_CYC    = 2;
    localparam int MULT       = 4;

    logic clk       = 1'b0;
    logic rst       = 1'b1;
    logic mult_sel  = 1'b0;
    logic idle_req  = 1'b0;
    logic pdown_req = 1'b0;
    logic cpu_ph1, cpu_ph2, per_ph1, per_ph2, clkout_int, state_stb;

    int n_vec = 0;
    int n_bad = 0;

    // bench-side expectation state
    bit m_first;
    int m_pos;
    int m_half;
    bit m_run_cpu, m_run_per, m_clk;
    bit e_cpu1, e_cpu2, e_per1, e_per2, e_stb;

    state_phase_gen #(
        .SUB_CYC (SUB_CYC),
        .MULT    (MULT)
    ) u_state_phase_gen (
        .clk        (clk),
        .rst        (rst),
        .mult_sel   (mult_sel),
        .idle_req   (idle_req),
        .pdown_req  (pdown_req),
        .cpu_ph1    (cpu_ph1),
        .cpu_ph2    (cpu_ph2),
        .per_ph1    (per_ph1),
        .per_ph2    (per_ph2),
        .clkout_int (clkout_int),
        .state_stb  (state_stb)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk_bit(input string tag, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_first   = 1'b1;
        m_pos     = 0;
        m_half    = SUB_CYC * MULT;
        m_run_cpu = 1'b1;
        m_run_per = 1'b1;
        m_clk     = 1'b0;
        e_cpu1 = 0; e_cpu2 = 0; e_per1 = 0; e_per2 = 0; e_stb = 0;
    endtask

    // One clock: expectation from the requirements, then compare away from the edge
    task automatic step();
        bit wrap;
        bit nclk;
        @(posedge clk);
        nclk = e_per1 ? 1'b1 : (e_per2 ? 1'b0 : m_clk);           // R5
        wrap = m_first || (m_pos == 2 * m_half - 1);
        if (wrap) begin                                           // R8: sample only here
            m_pos     = 0;
            m_half    = mult_sel ? SUB_CYC : SUB_CYC * MULT;      // R1 R2
            m_run_per = !pdown_req;                               // R7
            m_run_cpu = !(pdown_req || idle_req);                 // R6
            m_first   = 1'b0;
        end else begin
            m_pos++;
        end
        m_clk  = nclk;
        e_stb  = (m_pos == 0);
        e_per1 = (m_pos == 0) && m_run_per;
        e_per2 = (m_pos == m_half) && m_run_per;
        e_cpu1 = (m_pos == 0) && m_run_cpu;
        e_cpu2 = (m_pos == m_half) && m_run_cpu;
        @(negedge clk);
        chk_bit("R6", "cpu_ph1", cpu_ph1, e_cpu1);
        chk_bit("R6", "cpu_ph2", cpu_ph2, e_cpu2);
        chk_bit("R3", "per_ph1", per_ph1, e_per1);
        chk_bit("R3", "per_ph2", per_ph2, e_per2);
        chk_bit("R5", "clkout_int", clkout_int, m_clk);
        chk_bit("R4", "state_stb", state_stb, e_stb);
    endtask

    task automatic hold_reset(input int n);
        rst = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        chk_bit("R9", "reset cpu_ph1", cpu_ph1, 1'b0);
        chk_bit("R9", "reset cpu_ph2", cpu_ph2, 1'b0);
        chk_bit("R9", "reset per_ph1", per_ph1, 1'b0);
        chk_bit("R9", "reset per_ph2", per_ph2, 1'b0);
        chk_bit("R9", "reset clkout_int", clkout_int, 1'b0);
        chk_bit("R9", "reset state_stb", state_stb, 1'b0);
        model_reset();
        rst = 1'b0;
    endtask

    // Step at least once, then up to the next state start, then count one state
    task automatic measure(input int exp_len, input int exp_half, input string tag);
        int g;
        int cnt;
        int h;
        g = 0;
        step();
        while (!state_stb && g < 64) begin
            step();
            g++;
        end
        cnt = 0;
        h   = -1;
        do begin
            step();
            cnt++;
            if (per_ph2 && h < 0) h = cnt;
        end while (!state_stb && cnt < 64);
        chk_int(tag, "state length", cnt, exp_len);
        chk_int(tag, "second phase offset", h, exp_half);
    endtask

    // Advance to a state start, then count pulses over that state (fast mode)
    task automatic count_state(output int n_cpu, output int n_per, output int n_clk);
        int g;
        g = 0;
        step();
        while (!state_stb && g < 64) begin
            step();
            g++;
        end
        n_cpu = int'(cpu_ph1) + int'(cpu_ph2);
        n_per = int'(per_ph1) + int'(per_ph2);
        n_clk = int'(clkout_int);
        repeat (2 * SUB_CYC - 1) begin
            step();
            n_cpu += int'(cpu_ph1) + int'(cpu_ph2);
            n_per += int'(per_ph1) + int'(per_ph2);
            n_clk += int'(clkout_int);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        int nc, np, nk;
        model_reset();
        mult_sel = 1'b1;
        hold_reset(3);

        // R9: first edge after release opens a state at phase 1
        step();
        chk_bit("R9", "first per_ph1", per_ph1, 1'b1);
        chk_bit("R9", "first state_stb", state_stb, 1'b1);

        // R1: multiplied rate
        measure(2 * SUB_CYC, SUB_CYC, "R1");

        // R2: direct rate
        mult_sel = 1'b0;
        measure(2 * SUB_CYC * MULT, SUB_CYC * MULT, "R2");

        // R8: rate change inside a direct-rate state does not alter it
        mult_sel = 1'b1;
        repeat (SUB_CYC * MULT) step();
        chk_bit("R8", "second phase kept at old offset", per_ph2, 1'b1);
        repeat (SUB_CYC * MULT) step();
        chk_bit("R8", "state kept old length", state_stb, 1'b1);

        // R6: idle halts processor phases only
        idle_req = 1'b1;
        count_state(nc, np, nk);
        chk_int("R6", "cpu pulses in idle state", nc, 0);
        chk_int("R6", "peripheral pulses in idle state", np, 2);

        // R7: powerdown halts everything, also with idle high
        pdown_req = 1'b1;
        count_state(nc, np, nk);
        count_state(nc, np, nk);
        chk_int("R7", "cpu pulses in powerdown", nc, 0);
        chk_int("R7", "peripheral pulses in powerdown", np, 0);
        chk_int("R7", "clkout high cycles in powerdown", nk, 0);
        chk_bit("R4", "strobe runs in powerdown", state_stb, 1'b0);
        idle_req  = 1'b0;
        pdown_req = 1'b0;

        // Sweep of rate and request combinations with varying hold lengths
        for (int pass = 0; pass < 3; pass++) begin
            for (int s = 0; s < 2; s++) begin
                for (int r = 0; r < 4; r++) begin
                    mult_sel  = s[0];
                    idle_req  = r[0];
                    pdown_req = r[1];
                    repeat (5 + 3 * r + 7 * s + 4 * pass) step();
                end
            end
        end

        // R9: reset taken during powerdown
        idle_req  = 1'b0;
        pdown_req = 1'b1;
        repeat (10) step();
        rst = 1'b1;
        @(posedge clk);
        pdown_req = 1'b0;
        hold_reset(2);
        step();
        chk_bit("R9", "per_ph1 after reset from powerdown", per_ph1, 1'b1);
        chk_bit("R9", "cpu_ph1 after reset from powerdown", cpu_ph1, 1'b1);
        repeat (40) step();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule